// File: doc/BRIEF.md
# Operand Forwarding and Interlock Controller

This block makes the data-hazard decisions for an in-order scalar pipeline of six stages: fetch, decode, register read, ALU, memory and write-back. One instruction enters per cycle in steady state. The instruction sitting in register read names two source registers. The block compares each of them with the destination of the older instructions now in the ALU and memory stages. For each operand it chooses where the value comes from: the register file, the ALU-stage result or the memory-stage result.

Some values cannot be forwarded in time. A load that is still in the ALU stage delivers its data only at the end of the memory stage. In that case the block holds fetch, decode and register read, and it injects a bubble into the ALU stage. The bubble is a nop with no register write. A mode input can switch forwarding off. The block then stalls the consumer until every matching producer has left the memory stage. The register file is written in the first half of a cycle and read in the second, so a producer in write-back never needs a forwarding path.

The block is purely combinational and holds no state. Its inputs come from the pipeline registers and its outputs steer the operand multiplexers and the stage enables in the same cycle. None of its pins carry a data stream, so there is no valid/ready handshake and no back-pressure to describe. Stage occupancy is given by plain valid bits.

Top module: `operand_bypass_ctrl`

## Requirements
- R1: Operand select encoding is 0 = register file, 1 = ALU-stage result, 2 = memory-stage result. When no producer matches, both selects are 0 and no stall is raised.
- R2: In forwarding mode (`fwd_mode`=1), a source equal to the destination of a valid, writing, non-load ALU-stage instruction gets select 1, and no stall is raised.
- R3: In forwarding mode, a source equal to the destination of a valid, writing memory-stage instruction gets select 2. This holds whether or not that instruction is a load.
- R4: When the ALU-stage and memory-stage producers both match the same source, select 1 (the younger, ALU-stage result) wins.
- R5: Register 0 never matches. A source of 0 always gets select 0 and never causes a stall.
- R6: A producer whose valid bit or register-write enable is 0 is ignored for both selection and stalling.
- R7: In forwarding mode, a valid load in the ALU stage whose destination matches either source raises a stall.
- R8: In stall-only mode (`fwd_mode`=0), any match against an ALU-stage or memory-stage producer raises a stall, and both selects are always 0.
- R9: When register read holds no valid instruction (`rr_valid`=0), no stall is raised and both selects are 0.
- R10: A stall is all or nothing. `hold_fetch`, `hold_decode`, `hold_rr` and `bubble_alu` are always equal.
- R11: The two operands are resolved independently. A match on one source does not change the select of the other. During a stall, the selects still report the forwarding choice for the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fwd_mode | input | 1 | 1 = forwarding policy, 0 = stall-only policy |
| rr_valid | input | 1 | Register-read stage holds an instruction |
| rr_src1 | input | REG_W | First source register number |
| rr_src2 | input | REG_W | Second source register number |
| alu_valid | input | 1 | ALU stage holds an instruction |
| alu_wen | input | 1 | ALU-stage instruction writes a register |
| alu_is_load | input | 1 | ALU-stage instruction is a load |
| alu_dst | input | REG_W | ALU-stage destination register |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_W | Memory-stage destination register |
| sel_a | output | 2 | Operand source select for first source |
| sel_b | output | 2 | Operand source select for second source |
| hold_fetch | output | 1 | Hold fetch stage |
| hold_decode | output | 1 | Hold decode stage |
| hold_rr | output | 1 | Hold register-read stage |
| bubble_alu | output | 1 | Insert nop into ALU stage |

## Verification
Two decisions can coincide in one cycle. One source can be forwarded from the memory stage while the other source is held up by a load in the ALU stage. The bench builds this case on purpose: a load in the ALU stage targets the second source while a writing instruction in the memory stage targets the first. It then expects the stall outputs and select 2 on the first operand together. A second overlap occurs when both producers name the same register, and that case is judged by the ALU-stage priority.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_ALU     = 2'd1,
    SRC_MEM     = 2'd2
  } opnd_src_e;
endpackage

// File: rtl/hz_match.sv
module hz_match #(
  parameter int REG_W = 5
) (
  input  logic             prod_valid,
  input  logic             prod_wen,
  input  logic [REG_W-1:0] prod_dst,
  input  logic [REG_W-1:0] src,
  output logic             hit
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  always_comb begin
    hit = prod_valid && prod_wen && (prod_dst != ZERO_REG) && (prod_dst == src);
  end
endmodule

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
  import hz_pkg::*;
(
  input  logic      fwd_en,
  input  logic      hit_alu,
  input  logic      hit_mem,
  output opnd_src_e sel
);
  always_comb begin
    sel = SRC_REGFILE;
    if (fwd_en) begin
      if (hit_alu)      sel = SRC_ALU;
      else if (hit_mem) sel = SRC_MEM;
    end
  end

  always_comb begin
    if (!$isunknown({fwd_en, hit_alu, hit_mem}))
      AST_ALU_WINS: assert (!(fwd_en && hit_alu) || sel == SRC_ALU); // R4
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int NSRC = 2
) (
  input  logic            rr_valid,
  input  logic            fwd_mode,
  input  logic            alu_is_load,
  input  logic [NSRC-1:0] hit_alu,
  input  logic [NSRC-1:0] hit_mem,
  output logic            stall
);
  logic any_alu, any_mem;

  always_comb begin
    any_alu = |hit_alu;
    any_mem = |hit_mem;
    if (!rr_valid)     stall = 1'b0;
    else if (fwd_mode) stall = any_alu && alu_is_load;
    else               stall = any_alu || any_mem;
  end

  always_comb begin
    if (!$isunknown({rr_valid, fwd_mode, alu_is_load, hit_alu, hit_mem})) begin
      AST_IDLE_NO_STALL: assert (rr_valid || !stall); // R9
      AST_MEM_NEVER_STALLS_FWD: assert (!(fwd_mode && !any_alu) || !stall); // R3
    end
  end
endmodule

// File: rtl/operand_bypass_ctrl.sv
module operand_bypass_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             fwd_mode,
  input  logic             rr_valid,
  input  logic [REG_W-1:0] rr_src1,
  input  logic [REG_W-1:0] rr_src2,
  input  logic             alu_valid,
  input  logic             alu_wen,
  input  logic             alu_is_load,
  input  logic [REG_W-1:0] alu_dst,
  input  logic             mem_valid,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             hold_fetch,
  output logic             hold_decode,
  output logic             hold_rr,
  output logic             bubble_alu
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] src_num [NSRC];
  logic [NSRC-1:0]  hit_alu;
  logic [NSRC-1:0]  hit_mem;
  opnd_src_e        sel [NSRC];
  logic             stall;
  logic             fwd_en;

  assign src_num[0] = rr_src1;
  assign src_num[1] = rr_src2;
  assign fwd_en     = fwd_mode && rr_valid;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    hz_match #(.REG_W(REG_W)) u_cmp_alu (
      .prod_valid (alu_valid),
      .prod_wen   (alu_wen),
      .prod_dst   (alu_dst),
      .src        (src_num[i]),
      .hit        (hit_alu[i])
    );
    hz_match #(.REG_W(REG_W)) u_cmp_mem (
      .prod_valid (mem_valid),
      .prod_wen   (mem_wen),
      .prod_dst   (mem_dst),
      .src        (src_num[i]),
      .hit        (hit_mem[i])
    );
    hz_operand_sel u_sel (
      .fwd_en  (fwd_en),
      .hit_alu (hit_alu[i]),
      .hit_mem (hit_mem[i]),
      .sel     (sel[i])
    );
  end

  hz_interlock #(.NSRC(NSRC)) u_lock (
    .rr_valid    (rr_valid),
    .fwd_mode    (fwd_mode),
    .alu_is_load (alu_is_load),
    .hit_alu     (hit_alu),
    .hit_mem     (hit_mem),
    .stall       (stall)
  );

  assign sel_a       = sel[0];
  assign sel_b       = sel[1];
  assign hold_fetch  = stall;
  assign hold_decode = stall;
  assign hold_rr     = stall;
  assign bubble_alu  = stall;

  always_comb begin
    if (!$isunknown({fwd_mode, rr_valid, rr_src1, rr_src2, alu_valid, alu_wen,
                     alu_is_load, alu_dst, mem_valid, mem_wen, mem_dst})) begin
      AST_STALL_GROUP: assert (hold_fetch == bubble_alu && hold_decode == bubble_alu
                               && hold_rr == bubble_alu); // R10
      AST_SRC0_FROM_RF: assert (rr_src1 != '0 || sel_a == 2'd0); // R5
      AST_STALL_MODE_RF: assert (fwd_mode || (sel_a == 2'd0 && sel_b == 2'd0)); // R8
      AST_LOAD_USE: assert (!(fwd_mode && rr_valid && alu_is_load && (sel_a == 2'd1
                            || sel_b == 2'd1)) || bubble_alu); // R7
    end
  end
endmodule

// File: tb/operand_bypass_ctrl_test.sv
module operand_bypass_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_mode, rr_valid, alu_valid, alu_wen, alu_is_load, mem_valid, mem_wen;
  logic [REG_W-1:0] rr_src1, rr_src2, alu_dst, mem_dst;
  logic [1:0] sel_a, sel_b;
  logic hold_fetch, hold_decode, hold_rr, bubble_alu;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_bypass_ctrl #(.REG_W(REG_W)) uut (
    .fwd_mode, .rr_valid, .rr_src1, .rr_src2, .alu_valid, .alu_wen, .alu_is_load,
    .alu_dst, .mem_valid, .mem_wen, .mem_dst, .sel_a, .sel_b, .hold_fetch,
    .hold_decode, .hold_rr, .bubble_alu
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic fm, input logic rv, input int s1, input int s2,
                       input logic av, input logic aw, input logic al, input int ad,
                       input logic mv, input logic mw, input int md);
    @(negedge clk);
    fwd_mode = fm; rr_valid = rv; rr_src1 = REG_W'(s1); rr_src2 = REG_W'(s2);
    alu_valid = av; alu_wen = aw; alu_is_load = al; alu_dst = REG_W'(ad);
    mem_valid = mv; mem_wen = mw; mem_dst = REG_W'(md);
    #1;
  endtask

  task automatic expect_all(input string tag, input int ea, input int eb, input int es);
    check({tag, " sel_a"}, int'(sel_a), ea);
    check({tag, " sel_b"}, int'(sel_b), eb);
    check({tag, " hold_fetch"}, int'(hold_fetch), es);
    check({tag, " hold_decode"}, int'(hold_decode), es);
    check({tag, " hold_rr"}, int'(hold_rr), es);
    check({tag, " bubble_alu"}, int'(bubble_alu), es);
  endtask

  task automatic t_reset_idle();
    drive(1, 1, 1, 2, 0, 0, 0, 0, 0, 0, 0);
    expect_all("R1 no match", 0, 0, 0);
    drive(1, 1, 6, 8, 1, 1, 0, 9, 1, 1, 10);
    expect_all("R1 other regs", 0, 0, 0);
  endtask

  task automatic t_alu_fwd();
    drive(1, 1, 5, 7, 1, 1, 0, 5, 0, 0, 0);
    expect_all("R2 alu fwd rs1 / R11", 1, 0, 0);
    drive(1, 1, 4, 12, 1, 1, 0, 12, 0, 0, 0);
    expect_all("R2 alu fwd rs2 / R11", 0, 1, 0);
  endtask

  task automatic t_mem_fwd();
    drive(1, 1, 5, 7, 0, 0, 0, 0, 1, 1, 7);
    expect_all("R3 mem fwd rs2 / R11", 0, 2, 0);
    drive(1, 1, 20, 20, 1, 1, 0, 3, 1, 1, 20);
    expect_all("R3 mem fwd both", 2, 2, 0);
  endtask

  task automatic t_priority();
    drive(1, 1, 3, 3, 1, 1, 0, 3, 1, 1, 3);
    expect_all("R4 alu over mem", 1, 1, 0);
    drive(1, 1, 3, 6, 1, 1, 0, 6, 1, 1, 3);
    expect_all("R4 split", 2, 1, 0);
  endtask

  task automatic t_zero();
    drive(1, 1, 0, 0, 1, 1, 1, 0, 1, 1, 0);
    expect_all("R5 reg0 fwd mode", 0, 0, 0);
    drive(0, 1, 0, 0, 1, 1, 0, 0, 1, 1, 0);
    expect_all("R5 reg0 stall mode", 0, 0, 0);
  endtask

  task automatic t_gating();
    drive(1, 1, 5, 7, 0, 1, 1, 5, 1, 0, 7);
    expect_all("R6 invalid alu / nowrite mem", 0, 0, 0);
    drive(0, 1, 5, 7, 1, 0, 0, 5, 0, 1, 7);
    expect_all("R6 stall mode gated", 0, 0, 0);
  endtask

  task automatic t_load_use();
    drive(1, 1, 4, 9, 1, 1, 1, 9, 1, 1, 4);
    expect_all("R7 load-use with mem fwd / R10 / R11", 2, 1, 1);
    drive(1, 1, 9, 2, 1, 1, 1, 9, 0, 0, 0);
    expect_all("R7 load-use rs1", 1, 0, 1);
  endtask

  task automatic t_stall_mode();
    drive(0, 1, 5, 7, 1, 1, 0, 5, 0, 0, 0);
    expect_all("R8 alu match stalls", 0, 0, 1);
    drive(0, 1, 5, 7, 0, 0, 0, 0, 1, 1, 7);
    expect_all("R8 mem match stalls", 0, 0, 1);
    drive(0, 1, 5, 7, 1, 1, 0, 8, 1, 1, 9);
    expect_all("R8 no match", 0, 0, 0);
  endtask

  task automatic t_idle_rr();
    drive(1, 0, 9, 9, 1, 1, 1, 9, 1, 1, 9);
    expect_all("R9 empty rr fwd mode", 0, 0, 0);
    drive(0, 0, 9, 9, 1, 1, 0, 9, 1, 1, 9);
    expect_all("R9 empty rr stall mode", 0, 0, 0);
  endtask

  initial begin
    fwd_mode = 0; rr_valid = 0; rr_src1 = '0; rr_src2 = '0;
    alu_valid = 0; alu_wen = 0; alu_is_load = 0; alu_dst = '0;
    mem_valid = 0; mem_wen = 0; mem_dst = '0;
    repeat (2) @(negedge clk);
    #1;
    expect_all("R1 reset state", 0, 0, 0);
    rst_n = 1'b1;
    t_reset_idle();
    t_alu_fwd();
    t_mem_fwd();
    t_priority();
    t_zero();
    t_gating();
    t_load_use();
    t_stall_mode();
    t_idle_rr();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule